// File: doc/BRIEF.md
# Bus Access Watchpoint Comparator

This block watches every bus access and raises a one-clock match pulse when the access meets a set of programmed conditions. Each access is presented for one cycle with a valid strobe, together with its byte address, a read/write flag, a word/byte size flag and the data bus. The conditions are the exact address, an optional direction, an optional size and an optional masked data pattern.

Configuration is loaded through a small write port with a register select, a write strobe and write data. All configuration resets to zero, which leaves the comparator disabled. A word access always names its lower byte address. The byte at that lower address travels on the upper data lane and is compared against the upper half of the data value. A word access that starts one byte below the programmed address never matches, even though it touches that address.

The match output is registered. It is meant to feed sequencing or breakpoint logic that lies outside this block.

Top module: `bus_watch_cmp`

## Requirements
- R1: After reset every configuration field is zero and `matchPulse` is 0. With that configuration, no access produces a match.
- R2: When the enable bit (bit 0 of the control register, select 0) is 0, `matchPulse` stays 0 for every access.
- R3: A match requires `busAddr` to equal the compare address (select 1) exactly. A word access at the compare address minus one never matches.
- R4: When the direction-enable bit (control bit 1) is 1, only accesses whose `busRnw` equals the direction bit (control bit 2, 1 = read) match. When direction-enable is 0, reads and writes both match.
- R5: When the size-enable bit (control bit 3) is 1, only accesses whose `busWord` equals the size bit (control bit 4, 1 = word) match. So a word access covering a byte-configured address does not match.
- R6: When size-enable is 0, both byte and word accesses to the compare address match.
- R7: When data compare (control bit 5) is on and the access is a word, `busData[15:8]` is compared with value bits [15:8] and `busData[7:0]` with value bits [7:0]. The data value is at select 2.
- R8: When data compare is on and the access is a byte, only one lane is compared. That lane is `busData[15:8]` against value [15:8] for an even address, and `busData[7:0]` against value [7:0] for an odd address.
- R9: The mask register (select 3) picks the data bits that take part in the compare. A mask bit of 0 excludes that bit.
- R10: When data compare is off, `busData` has no effect on the match.
- R11: `matchPulse` is 1 for exactly the one clock after each cycle in which `busValid` is 1 and all enabled conditions hold. It is 0 after any cycle in which `busValid` is 0.
- R12: A configuration write takes effect for accesses in the cycles after its strobe. Writes to selects 4 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 3 | Configuration register select |
| cfgWdata | input | 16 | Configuration write data |
| busValid | input | 1 | Access present this cycle |
| busAddr | input | 16 | Access byte address (lower address for a word) |
| busRnw | input | 1 | 1 = read, 0 = write |
| busWord | input | 1 | 1 = word access, 0 = byte access |
| busData | input | 16 | Data bus, upper lane carries the lower address |
| matchPulse | output | 1 | Registered one-clock match indication |

## Verification
A qualifying access sampled at one rising edge shows up on `matchPulse` right after that edge, one register later. A configuration write sampled at an edge only governs accesses from the next edge onward. The reference model works out its expected value at each rising edge from the inputs and the model configuration as they stood before that edge. It updates its configuration afterwards and compares with `matchPulse` at the following falling edge, so each result is checked in the exact cycle it is due.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // control register bit positions (select 0)
  localparam int CTL_EN     = 0;
  localparam int CTL_DIREN  = 1;
  localparam int CTL_DIRRD  = 2;
  localparam int CTL_SIZEEN = 3;
  localparam int CTL_SIZEWD = 4;
  localparam int CTL_DATAEN = 5;
  localparam int CTL_BITS   = 6;

  // register selects
  localparam logic [2:0] SEL_CTL  = 3'd0;
  localparam logic [2:0] SEL_ADDR = 3'd1;
  localparam logic [2:0] SEL_VAL  = 3'd2;
  localparam logic [2:0] SEL_MASK = 3'd3;

  typedef struct packed {
    logic ldCtl;
    logic ldAddr;
    logic ldVal;
    logic ldMask;
    logic sample;
  } wpStrobe_t;

  typedef struct packed {
    logic enable;
    logic dirEn;
    logic dirRd;
    logic sizeEn;
    logic sizeWord;
    logic dataEn;
  } wpFlags_t;

endpackage

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import wp_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             busValid,
  output wpStrobe_t        strb
);

  always_comb begin
    strb        = '0;
    strb.sample = busValid;
    if (cfgWe) begin
      unique case (cfgSel)
        SEL_W'(SEL_CTL):  strb.ldCtl  = 1'b1;
        SEL_W'(SEL_ADDR): strb.ldAddr = 1'b1;
        SEL_W'(SEL_VAL):  strb.ldVal  = 1'b1;
        SEL_W'(SEL_MASK): strb.ldMask = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wp_lane_cmp.sv
module wp_lane_cmp #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] busLane,
  input  logic [LW-1:0] valLane,
  input  logic [LW-1:0] maskLane,
  output logic          laneEq
);

  logic [LW-1:0] diff;

  always_comb begin
    diff   = (busLane ^ valLane) & maskLane;
    laneEq = (diff == '0);
  end

endmodule

// File: rtl/wp_dpath.sv
module wp_dpath
  import wp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  wpStrobe_t     strb,
  input  logic [DW-1:0] cfgWdata,
  input  logic [AW-1:0] busAddr,
  input  logic          busRnw,
  input  logic          busWord,
  input  logic [DW-1:0] busData,
  output wpFlags_t      flagsQ,
  output logic [AW-1:0] cmpAddrQ,
  output logic [DW-1:0] valQ,
  output logic [DW-1:0] maskQ,
  output logic          matchQ
);

  localparam int LANES = DW / 8;
  localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0] laneEq;
  logic [LB-1:0]    laneSel;
  logic             addrOk, dirOk, sizeOk, dataOk, hit;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ   <= '0;
      cmpAddrQ <= '0;
      valQ     <= '0;
      maskQ    <= '0;
    end else begin
      if (strb.ldCtl) begin
        flagsQ.enable   <= cfgWdata[CTL_EN];
        flagsQ.dirEn    <= cfgWdata[CTL_DIREN];
        flagsQ.dirRd    <= cfgWdata[CTL_DIRRD];
        flagsQ.sizeEn   <= cfgWdata[CTL_SIZEEN];
        flagsQ.sizeWord <= cfgWdata[CTL_SIZEWD];
        flagsQ.dataEn   <= cfgWdata[CTL_DATAEN];
      end
      if (strb.ldAddr) cmpAddrQ <= cfgWdata[AW-1:0];
      if (strb.ldVal)  valQ     <= cfgWdata;
      if (strb.ldMask) maskQ    <= cfgWdata;
    end
  end

  // lane 0 is the uppermost byte and carries the lowest address
  for (genvar i = 0; i < LANES; i++) begin : gLane
    wp_lane_cmp #(.LW(8)) uLane (
      .busLane (busData[DW-1-8*i -: 8]),
      .valLane (valQ[DW-1-8*i -: 8]),
      .maskLane(maskQ[DW-1-8*i -: 8]),
      .laneEq  (laneEq[i])
    );
  end

  if (LANES > 1) begin : gSel
    assign laneSel = busAddr[LB-1:0];
  end else begin : gSelOne
    assign laneSel = '0;
  end

  always_comb begin
    addrOk = (busAddr == cmpAddrQ);
    dirOk  = !flagsQ.dirEn  || (busRnw  == flagsQ.dirRd);
    sizeOk = !flagsQ.sizeEn || (busWord == flagsQ.sizeWord);
    if (!flagsQ.dataEn)  dataOk = 1'b1;
    else if (busWord)    dataOk = &laneEq;
    else                 dataOk = laneEq[laneSel];
    hit = strb.sample && flagsQ.enable && addrOk && dirOk && sizeOk && dataOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= 1'b0;
    else       matchQ <= hit;
  end

endmodule

// File: rtl/bus_watch_cmp.sv
module bus_watch_cmp
  import wp_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic [DW-1:0]    cfgWdata,
  input  logic             busValid,
  input  logic [AW-1:0]    busAddr,
  input  logic             busRnw,
  input  logic             busWord,
  input  logic [DW-1:0]    busData,
  output logic             matchPulse
);

  wpStrobe_t     strb;
  wpFlags_t      flagsV;
  logic [AW-1:0] cmpAddrV;
  logic [DW-1:0] valV;
  logic [DW-1:0] maskV;

  wp_ctrl #(.SEL_W(SEL_W)) uCtrl (
    .cfgWe   (cfgWe),
    .cfgSel  (cfgSel),
    .busValid(busValid),
    .strb    (strb)
  );

  wp_dpath #(.AW(AW), .DW(DW)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cfgWdata(cfgWdata),
    .busAddr (busAddr),
    .busRnw  (busRnw),
    .busWord (busWord),
    .busData (busData),
    .flagsQ  (flagsV),
    .cmpAddrQ(cmpAddrV),
    .valQ    (valV),
    .maskQ   (maskV),
    .matchQ  (matchPulse)
  );

endmodule

// File: rtl/wp_checker.sv
module wp_checker
  import wp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          busValid,
  input logic [AW-1:0] busAddr,
  input logic          busRnw,
  input logic          busWord,
  input logic [DW-1:0] busData,
  input logic          matchPulse,
  input wpFlags_t      flagsV,
  input logic [AW-1:0] cmpAddrV,
  input logic [DW-1:0] valV,
  input logic [DW-1:0] maskV
);

  AST_NO_IDLE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(busValid)); // R11

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> $past(flagsV.enable)); // R2

  AST_ADDR_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(busAddr) == $past(cmpAddrV))); // R3

  AST_DIR_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(flagsV.dirEn)) |-> ($past(busRnw) == $past(flagsV.dirRd))); // R4

  AST_SIZE_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(flagsV.sizeEn)) |-> ($past(busWord) == $past(flagsV.sizeWord))); // R5

  AST_WORD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(flagsV.dataEn) && $past(busWord))
      |-> ((($past(busData) ^ $past(valV)) & $past(maskV)) == '0)); // R7

  AST_EVEN_BYTE_LANE: assert property (@(posedge clk) disable iff (!rstN)
    (matchPulse && $past(flagsV.dataEn) && !$past(busWord) && !$past(busAddr[0]))
      |-> ((($past(busData[DW-1 -: 8]) ^ $past(valV[DW-1 -: 8])) & $past(maskV[DW-1 -: 8])) == 8'h00)); // R8

endmodule

bind bus_watch_cmp wp_checker #(.AW(AW), .DW(DW)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busAddr   (busAddr),
  .busRnw    (busRnw),
  .busWord   (busWord),
  .busData   (busData),
  .matchPulse(matchPulse),
  .flagsV    (flagsV),
  .cmpAddrV  (cmpAddrV),
  .valV      (valV),
  .maskV     (maskV)
);

// File: tb/sim_bus_watch_cmp.sv
`timescale 1ns/1ps
module sim_bus_watch_cmp;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [15:0] cfgWdata = '0;
  logic        busValid = 1'b0;
  logic [15:0] busAddr = '0;
  logic        busRnw = 1'b0;
  logic        busWord = 1'b0;
  logic [15:0] busData = '0;
  logic        matchPulse;

  int    total = 0;
  int    bad = 0;
  string curReq = "R1";
  bit    done = 0;

  // model configuration
  logic [5:0]  mCtl = '0;
  logic [15:0] mAddr = '0, mVal = '0, mMask = '0;
  bit          expQ = 0;
  int          hits = 0;

  always #2 clk = ~clk;

  bus_watch_cmp u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .busValid(busValid), .busAddr(busAddr), .busRnw(busRnw), .busWord(busWord),
    .busData(busData), .matchPulse(matchPulse)
  );

  function automatic bit refMatch();
    logic [15:0] d;
    if (!busValid || !mCtl[0]) return 0;
    if (busAddr != mAddr) return 0;
    if (mCtl[1] && (busRnw != mCtl[2])) return 0;
    if (mCtl[3] && (busWord != mCtl[4])) return 0;
    if (mCtl[5]) begin
      d = (busData ^ mVal) & mMask;
      if (busWord) return d == 16'h0;
      if (busAddr[0] == 1'b0) return d[15:8] == 8'h00;
      return d[7:0] == 8'h00;
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      expQ = 0; mCtl = '0; mAddr = '0; mVal = '0; mMask = '0;
    end else begin
      expQ = refMatch();
      if (cfgWe) begin
        case (cfgSel)
          3'd0: mCtl  = cfgWdata[5:0];
          3'd1: mAddr = cfgWdata;
          3'd2: mVal  = cfgWdata;
          3'd3: mMask = cfgWdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (matchPulse !== expQ) begin
        bad++;
        $display("FAIL %s: matchPulse=%b expected=%b at %0t", curReq, matchPulse, expQ, $time);
      end
      if (expQ) hits++;
    end
  end

  task automatic cfgWrite(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1; cfgSel = s; cfgWdata = d;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic access(input logic [15:0] a, input bit rd, input bit wd, input logic [15:0] d);
    @(negedge clk);
    busValid = 1; busAddr = a; busRnw = rd; busWord = wd; busData = d;
    @(negedge clk);
    busValid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    curReq = "R1";
    access(16'h0000, 1, 0, 16'h0000);
    access(16'h0000, 0, 1, 16'hFFFF);

    curReq = "R12";
    cfgWrite(3'd1, 16'h1234);
    cfgWrite(3'd0, 16'h0001);
    access(16'h1234, 1, 0, 16'h0000);
    cfgWrite(3'd5, 16'h0000);
    cfgWrite(3'd4, 16'h4321);
    cfgWrite(3'd7, 16'hFFFF);
    access(16'h1234, 0, 1, 16'h0000);

    curReq = "R2";
    cfgWrite(3'd0, 16'h003E);
    access(16'h1234, 1, 0, 16'h0000);
    access(16'h1234, 1, 1, 16'h0000);

    curReq = "R3";
    cfgWrite(3'd0, 16'h0001);
    access(16'h1233, 1, 1, 16'h0000);
    access(16'h1235, 1, 0, 16'h0000);
    access(16'h0234, 1, 0, 16'h0000);
    access(16'h1234, 1, 1, 16'h0000);

    curReq = "R4";
    cfgWrite(3'd0, 16'h0007);
    access(16'h1234, 1, 0, 16'h0000);
    access(16'h1234, 0, 0, 16'h0000);
    cfgWrite(3'd0, 16'h0003);
    access(16'h1234, 1, 0, 16'h0000);
    access(16'h1234, 0, 0, 16'h0000);

    curReq = "R5";
    cfgWrite(3'd0, 16'h0009);
    access(16'h1234, 1, 1, 16'h0000);
    access(16'h1233, 1, 1, 16'h0000);
    access(16'h1234, 1, 0, 16'h0000);
    cfgWrite(3'd0, 16'h0019);
    access(16'h1234, 1, 1, 16'h0000);
    access(16'h1234, 1, 0, 16'h0000);

    curReq = "R6";
    cfgWrite(3'd0, 16'h0011);
    access(16'h1234, 0, 1, 16'h0000);
    access(16'h1234, 0, 0, 16'h0000);

    curReq = "R7";
    cfgWrite(3'd2, 16'hA55A);
    cfgWrite(3'd3, 16'hFFFF);
    cfgWrite(3'd0, 16'h0021);
    access(16'h1234, 0, 1, 16'hA55A);
    access(16'h1234, 0, 1, 16'h5AA5);
    access(16'h1234, 0, 1, 16'hA55B);
    access(16'h1234, 0, 1, 16'hA45A);

    curReq = "R8";
    access(16'h1234, 0, 0, 16'hA500);
    access(16'h1234, 0, 0, 16'h005A);
    cfgWrite(3'd1, 16'h1235);
    access(16'h1235, 1, 0, 16'h005A);
    access(16'h1235, 1, 0, 16'hA500);

    curReq = "R9";
    cfgWrite(3'd1, 16'h1234);
    cfgWrite(3'd3, 16'hF00F);
    access(16'h1234, 0, 1, 16'hA00A);
    access(16'h1234, 0, 1, 16'hAFFA);
    access(16'h1234, 0, 1, 16'h5FF5);

    curReq = "R10";
    cfgWrite(3'd0, 16'h0001);
    access(16'h1234, 0, 1, 16'h1111);
    access(16'h1234, 1, 0, 16'hFFFF);

    curReq = "R11";
    @(negedge clk);
    busValid = 1; busAddr = 16'h1234; busWord = 1;
    @(negedge clk);
    busAddr = 16'h1234; busWord = 0;
    @(negedge clk);
    busValid = 0;
    repeat (3) @(negedge clk);
    busAddr = 16'h1234;
    repeat (2) @(negedge clk);

    if (hits < 15) begin
      bad++;
      $display("FAIL R11: hits=%0d expected>=%0d", hits, 15);
    end
    total++;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run=%0d expected<%0d cycles", 100000, 100000);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule